// File: doc/BRIEF.md
# UART Loopback and Modem-Status Path

This block sits between a UART's register file, its transmit side and its receive buffer. It decides where each received entry comes from and what the modem-status flags show. When the loopback bit of the control register is clear, external receive bytes and external break events are pushed into the receive buffer. In that mode the modem-status flags follow the external modem pins through a synchronizer.

When loopback is set, the external receive side is cut off. Each byte written for transmission is pushed into the receive buffer instead, and each rising edge of the line-control break bit pushes a break entry. The modem-control outputs held in the control register are remapped crosswise onto the modem-status flags. The matching raw interrupt bits are loaded from the new flag values on every control write that leaves loopback on, including the write that first turns it on.

All behaviour works at byte level, one register stage from any strobe to its effect. The raw interrupt status also records each transmit write and can be cleared by a write-one-to-clear strobe.

Top module: `uart_lpbk_path`

## Requirements
- R1: A synchronous reset sets the following state: `ctl_q` is 0x0300 (both enables set, loopback off), `ris` is 0, `push_vld` is 0, and the break-bit history is cleared.
- R2: A control write (`ctl_wr`) stores `ctl_wdata` into `ctl_q` on the next edge. The bits that have meaning are: bit 13 OUT2, bit 12 OUT1, bit 11 RTS, bit 10 DTR, bit 9 receive enable, bit 8 transmit enable, bit 7 loopback, and bit 0 UART enable.
- R3: While `ctl_q[7]` is set, `flags[8]` (RI) equals OUT2, `flags[2]` (DCD) equals OUT1, `flags[0]` (CTS) equals RTS and `flags[1]` (DSR) equals DTR. All other `flags` bits are 0.
- R4: The mapping takes effect in the cycle after the control write that sets loopback, including a write that only sets bit 7. Every later control write with loopback set remaps the flags.
- R5: A control write whose data has bit 7 set loads the raw interrupt bits from the new flag values: `ris[0]` from RI, `ris[1]` from CTS, `ris[2]` from DCD and `ris[3]` from DSR. A control write without bit 7 leaves these bits unchanged.
- R6: Every transmit write (`tx_wr`) sets `ris[5]` on the next edge, whether or not loopback is on.
- R7: While in loopback, a transmit write pushes one entry one cycle later. The entry carries the byte in bits 7:0, and its bit 10 (break) is 0.
- R8: While in loopback, a break-bit write (`brk_wr`) that takes the break bit from 0 to 1 pushes a break entry (0x400). A write that keeps the bit at 1 pushes nothing, and so does a write that clears it. The break-bit history is updated in both modes.
- R9: While in loopback, external bytes (`ext_rx_vld`) and external breaks (`ext_brk`) push nothing.
- R10: Outside loopback, an external break pushes 0x400 and an external byte pushes the byte with bit 10 clear. A break wins over a byte in the same cycle, and transmit writes push nothing.
- R11: Outside loopback, `flags` shows the pins `modem_in` (bit 3 RI, bit 2 DCD, bit 1 DSR, bit 0 CTS) at the same flag positions as in R3. A pin change reaches `flags` on the second clock edge after it. The modem bits in `ctl_q` have no effect in this mode.
- R12: An interrupt-clear strobe (`icr_wr`) clears each `ris` bit whose `icr_mask` bit is 1. A transmit write or a loading control write in the same cycle wins over the clear for the bits it sets. The `ris` bits other than 0 to 3 and 5 always read 0.
- R13: In loopback, a transmit write and a rising break-bit write in the same cycle push only the transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_byte | input | 8 | Transmit byte |
| brk_wr | input | 1 | Line-control write strobe carrying the break bit |
| brk_val | input | 1 | New value of the break bit |
| ext_rx_vld | input | 1 | External received byte valid |
| ext_rx_byte | input | 8 | External received byte |
| ext_brk | input | 1 | External break event |
| modem_in | input | 4 | External modem pins {RI, DCD, DSR, CTS}, asynchronous |
| icr_wr | input | 1 | Raw interrupt clear strobe |
| icr_mask | input | 11 | Bits to clear in the raw interrupt status |
| ctl_q | output | 16 | Current control register value |
| flags | output | 9 | Modem-status flag bits at flag-register positions |
| ris | output | 11 | Raw interrupt status |
| push_vld | output | 1 | Receive buffer push strobe |
| push_data | output | 11 | Receive buffer entry, bit 10 marks a break |

## Verification
The bench targets the loopback write itself. A design that remapped the flags only on a later write, or that left the modem interrupt bits stale, shows old flags or old `ris` bits in the following cycle. It also covers break edge detection: a design that pushed on the break level would emit a second 0x400 while the bit is held, and one that tracked the history only in loopback would miss or invent an edge after a mode change. Further cases are the collisions (transmit with break, external break with external byte, clear with transmit set), where a wrong priority shows the wrong entry or a cleared bit. The last is the two-edge synchronizer latency outside loopback, where a design that was too fast or too slow would update `flags` in the wrong cycle.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;
    localparam int CTL_W    = 16;
    localparam int DATA_W   = 8;
    localparam int ENTRY_W  = DATA_W + 3;
    localparam int BRK_POS  = DATA_W + 2;
    localparam int FLAG_W   = 9;
    localparam int RIS_W    = 11;
    localparam int MODEM_W  = 4;
    localparam int RIS_TX   = 5;

    localparam int CB_OUT2  = 13;
    localparam int CB_OUT1  = 12;
    localparam int CB_RTS   = 11;
    localparam int CB_DTR   = 10;
    localparam int CB_LOOP  = 7;

    localparam logic [CTL_W-1:0]   CTL_RST   = 16'h0300;
    localparam logic [RIS_W-1:0]   RIS_USED  = 11'h02F;
    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_POS;

    typedef struct packed {
        logic ri;
        logic dcd;
        logic dsr;
        logic cts;
    } modem_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DATA,
        SRC_BREAK
    } push_src_e;

    function automatic modem_t ctl_to_modem(input logic [CTL_W-1:0] c);
        modem_t m;
        m.ri  = c[CB_OUT2];
        m.dcd = c[CB_OUT1];
        m.cts = c[CB_RTS];
        m.dsr = c[CB_DTR];
        return m;
    endfunction

    function automatic logic [FLAG_W-1:0] modem_to_flags(input modem_t m);
        logic [FLAG_W-1:0] f;
        f    = '0;
        f[8] = m.ri;
        f[2] = m.dcd;
        f[1] = m.dsr;
        f[0] = m.cts;
        return f;
    endfunction

    function automatic logic [MODEM_W-1:0] modem_to_ris(input modem_t m);
        return {m.dsr, m.dcd, m.cts, m.ri};
    endfunction
endpackage

// File: rtl/lpbk_sync.sv
module lpbk_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/lpbk_ctl.sv
module lpbk_ctl
    import uart_lpbk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic [CTL_W-1:0]     ctl_wdata,
    input  modem_t               pins_sync,
    output logic [CTL_W-1:0]     ctl_q,
    output logic                 loop_on,
    output logic [FLAG_W-1:0]    flags,
    output logic                 ris_load,
    output logic [MODEM_W-1:0]   ris_val
);
    modem_t cur_modem;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RST;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    assign loop_on   = ctl_q[CB_LOOP];
    assign cur_modem = loop_on ? ctl_to_modem(ctl_q) : pins_sync;
    assign flags     = modem_to_flags(cur_modem);
    assign ris_load  = ctl_wr & ctl_wdata[CB_LOOP];
    assign ris_val   = modem_to_ris(ctl_to_modem(ctl_wdata));
endmodule

// File: rtl/lpbk_rx_sel.sv
module lpbk_rx_sel
    import uart_lpbk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 loop_on,
    input  logic                 tx_wr,
    input  logic [DATA_W-1:0]    tx_byte,
    input  logic                 brk_wr,
    input  logic                 brk_val,
    input  logic                 ext_rx_vld,
    input  logic [DATA_W-1:0]    ext_rx_byte,
    input  logic                 ext_brk,
    output logic                 push_vld,
    output logic [ENTRY_W-1:0]   push_data
);
    logic              brk_q;
    logic              brk_rise;
    push_src_e         src;
    logic [DATA_W-1:0] sel_byte;
    logic [ENTRY_W-1:0] entry;

    assign brk_rise = brk_wr & brk_val & ~brk_q;

    always_comb begin
        src      = SRC_NONE;
        sel_byte = '0;
        if (loop_on) begin
            if (tx_wr) begin
                src      = SRC_DATA;
                sel_byte = tx_byte;
            end else if (brk_rise) begin
                src = SRC_BREAK;
            end
        end else begin
            if (ext_brk) begin
                src = SRC_BREAK;
            end else if (ext_rx_vld) begin
                src      = SRC_DATA;
                sel_byte = ext_rx_byte;
            end
        end
    end

    always_comb begin
        case (src)
            SRC_BREAK: entry = BRK_ENTRY;
            SRC_DATA:  entry = {{(ENTRY_W-DATA_W){1'b0}}, sel_byte};
            default:   entry = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q     <= 1'b0;
            push_vld  <= 1'b0;
            push_data <= '0;
        end else begin
            if (brk_wr) brk_q <= brk_val;
            push_vld  <= (src != SRC_NONE);
            push_data <= entry;
        end
    end
endmodule

// File: rtl/uart_lpbk_path.sv
module uart_lpbk_path
    import uart_lpbk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_wr,
    input  logic [CTL_W-1:0]     ctl_wdata,
    input  logic                 tx_wr,
    input  logic [DATA_W-1:0]    tx_byte,
    input  logic                 brk_wr,
    input  logic                 brk_val,
    input  logic                 ext_rx_vld,
    input  logic [DATA_W-1:0]    ext_rx_byte,
    input  logic                 ext_brk,
    input  logic [MODEM_W-1:0]   modem_in,
    input  logic                 icr_wr,
    input  logic [RIS_W-1:0]     icr_mask,
    output logic [CTL_W-1:0]     ctl_q,
    output logic [FLAG_W-1:0]    flags,
    output logic [RIS_W-1:0]     ris,
    output logic                 push_vld,
    output logic [ENTRY_W-1:0]   push_data
);
    logic [MODEM_W-1:0] pins_q;
    logic               loop_on;
    logic               ris_load;
    logic [MODEM_W-1:0] ris_val;
    logic [RIS_W-1:0]   ris_nxt;

    lpbk_sync #(.W(MODEM_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (modem_in),
        .q   (pins_q)
    );

    lpbk_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .pins_sync (modem_t'(pins_q)),
        .ctl_q     (ctl_q),
        .loop_on   (loop_on),
        .flags     (flags),
        .ris_load  (ris_load),
        .ris_val   (ris_val)
    );

    lpbk_rx_sel u_sel (
        .clk         (clk),
        .rst         (rst),
        .loop_on     (loop_on),
        .tx_wr       (tx_wr),
        .tx_byte     (tx_byte),
        .brk_wr      (brk_wr),
        .brk_val     (brk_val),
        .ext_rx_vld  (ext_rx_vld),
        .ext_rx_byte (ext_rx_byte),
        .ext_brk     (ext_brk),
        .push_vld    (push_vld),
        .push_data   (push_data)
    );

    always_comb begin
        ris_nxt = ris;
        if (icr_wr)   ris_nxt = ris_nxt & ~icr_mask;
        if (tx_wr)    ris_nxt[RIS_TX] = 1'b1;
        if (ris_load) ris_nxt[MODEM_W-1:0] = ris_val;
        ris_nxt = ris_nxt & RIS_USED;
    end

    always_ff @(posedge clk) begin
        if (rst) ris <= '0;
        else     ris <= ris_nxt;
    end
endmodule

// File: rtl/uart_lpbk_chk.sv
module uart_lpbk_chk
    import uart_lpbk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ctl_wr,
    input logic [CTL_W-1:0]   ctl_wdata,
    input logic               tx_wr,
    input logic [DATA_W-1:0]  tx_byte,
    input logic               brk_wr,
    input logic               ext_brk,
    input logic [CTL_W-1:0]   ctl_q,
    input logic [FLAG_W-1:0]  flags,
    input logic [RIS_W-1:0]   ris,
    input logic               push_vld,
    input logic [ENTRY_W-1:0] push_data
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_q == CTL_RST && ris == '0 && !push_vld));

    // R4
    loop_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[CB_LOOP]) |=>
            (flags == modem_to_flags(ctl_to_modem($past(ctl_wdata)))));

    // R5
    loop_write_ris_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[CB_LOOP]) |=>
            (ris[MODEM_W-1:0] == modem_to_ris(ctl_to_modem($past(ctl_wdata)))));

    // R6
    tx_sets_ris_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> ris[RIS_TX]);

    // R7
    loop_tx_push_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[CB_LOOP] && tx_wr) |=>
            (push_vld && push_data == {{(ENTRY_W-DATA_W){1'b0}}, $past(tx_byte)}));

    // R9
    loop_ext_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[CB_LOOP] && !tx_wr && !brk_wr) |=> !push_vld);

    // R10
    ext_break_push_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q[CB_LOOP] && ext_brk) |=> (push_vld && push_data == BRK_ENTRY));
endmodule

bind uart_lpbk_path uart_lpbk_chk u_chk (.*);

// File: tb/uart_lpbk_path_bench.sv
module uart_lpbk_path_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_wr;
    logic [15:0] ctl_wdata;
    logic        tx_wr;
    logic [7:0]  tx_byte;
    logic        brk_wr;
    logic        brk_val;
    logic        ext_rx_vld;
    logic [7:0]  ext_rx_byte;
    logic        ext_brk;
    logic [3:0]  modem_in;
    logic        icr_wr;
    logic [10:0] icr_mask;
    logic [15:0] ctl_q;
    logic [8:0]  flags;
    logic [10:0] ris;
    logic        push_vld;
    logic [10:0] push_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    logic [15:0] m_ctl;
    logic [10:0] m_ris;
    logic        m_brk;
    logic [3:0]  m_pins;

    always #2 clk = ~clk;

    uart_lpbk_path u_uart_lpbk_path (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .brk_wr(brk_wr), .brk_val(brk_val),
        .ext_rx_vld(ext_rx_vld), .ext_rx_byte(ext_rx_byte), .ext_brk(ext_brk),
        .modem_in(modem_in), .icr_wr(icr_wr), .icr_mask(icr_mask),
        .ctl_q(ctl_q), .flags(flags), .ris(ris),
        .push_vld(push_vld), .push_data(push_data)
    );

    function automatic logic [8:0] ctl_flags(input logic [15:0] c);
        logic [8:0] f = '0;
        f[8] = c[13];
        f[2] = c[12];
        f[0] = c[11];
        f[1] = c[10];
        return f;
    endfunction

    function automatic logic [8:0] pin_flags(input logic [3:0] p);
        logic [8:0] f = '0;
        f[8] = p[3];
        f[2] = p[2];
        f[1] = p[1];
        f[0] = p[0];
        return f;
    endfunction

    function automatic logic [3:0] flags_to_ris(input logic [8:0] f);
        return {f[1], f[2], f[0], f[8]};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctl_wr = 0; ctl_wdata = '0; tx_wr = 0; tx_byte = '0;
        brk_wr = 0; brk_val = 0; ext_rx_vld = 0; ext_rx_byte = '0;
        ext_brk = 0; icr_wr = 0; icr_mask = '0;
    endtask

    task automatic step(input logic cw, input logic [15:0] cd,
                        input logic tw, input logic [7:0] tb,
                        input logic bw, input logic bv,
                        input logic rv, input logic [7:0] rb, input logic eb,
                        input logic iw, input logic [10:0] im);
        logic        lb;
        logic        e_vld;
        logic [10:0] e_data;
        string       ptag;
        ctl_wr = cw; ctl_wdata = cd; tx_wr = tw; tx_byte = tb;
        brk_wr = bw; brk_val = bv; ext_rx_vld = rv; ext_rx_byte = rb;
        ext_brk = eb; icr_wr = iw; icr_mask = im;
        lb = m_ctl[7];
        e_vld = 0; e_data = '0; ptag = "R9 loopback push";
        if (lb) begin
            if (tw) begin
                e_vld = 1; e_data = {3'b000, tb};
                ptag = (bw && bv && !m_brk) ? "R13 tx over break" : "R7 loopback tx push";
            end else if (bw && bv && !m_brk) begin
                e_vld = 1; e_data = 11'h400; ptag = "R8 break rise push";
            end else if (bw) begin
                ptag = "R8 break no edge";
            end
        end else begin
            ptag = "R10 external push";
            if (eb) begin
                e_vld = 1; e_data = 11'h400;
            end else if (rv) begin
                e_vld = 1; e_data = {3'b000, rb};
            end
        end
        if (bw) m_brk = bv;
        if (iw) m_ris = m_ris & ~im;
        if (tw) m_ris[5] = 1'b1;
        if (cw && cd[7]) m_ris[3:0] = flags_to_ris(ctl_flags(cd));
        m_ris = m_ris & 11'h02F;
        if (cw) m_ctl = cd;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check(push_vld == e_vld, ptag, 32'(push_vld), 32'(e_vld));
        if (e_vld) check(push_data == e_data, ptag, 32'(push_data), 32'(e_data));
        check(ris == m_ris, "R5 R6 R12 ris", 32'(ris), 32'(m_ris));
        check(ctl_q == m_ctl, "R2 ctl_q", 32'(ctl_q), 32'(m_ctl));
        if (m_ctl[7])
            check(flags == ctl_flags(m_ctl), "R3 R4 loopback flags", 32'(flags),
                  32'(ctl_flags(m_ctl)));
        else
            check(flags == pin_flags(m_pins), "R11 pin flags", 32'(flags),
                  32'(pin_flags(m_pins)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_inputs();
        modem_in = 4'b0000;
        rst = 1'b1;
        m_ctl = 16'h0300; m_ris = '0; m_brk = 0; m_pins = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        check(ctl_q == 16'h0300, "R1 ctl reset", 32'(ctl_q), 32'h300);
        check(ris == '0, "R1 ris reset", 32'(ris), 0);
        check(push_vld == 1'b0, "R1 push reset", 32'(push_vld), 0);
        check(flags == '0, "R1 flags reset", 32'(flags), 0);

        // R11: outside loopback, ctl modem bits do nothing; pins latency
        step(1, 16'h3F01, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        modem_in = 4'b1011;
        @(posedge clk); @(negedge clk);
        check(flags == 9'h000, "R11 one edge no change", 32'(flags), 0);
        @(posedge clk); @(negedge clk);
        check(flags == 9'h103, "R11 two edges", 32'(flags), 32'h103);
        m_pins = 4'b1011;

        // R4 R3 R5: write that sets loopback with all modem outputs
        step(1, 16'h3C80, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check(flags == 9'h107, "R4 all outputs", 32'(flags), 32'h107);
        check(ris[3:0] == 4'hF, "R5 all modem ris", 32'(ris[3:0]), 32'hF);
        // R3 only OUT2, then only DTR
        step(1, 16'h2080, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check(ris[3:0] == 4'h1, "R5 ri only", 32'(ris[3:0]), 1);
        step(1, 16'h0480, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R7 R6 loopback transmit
        step(0, 0, 1, 8'hA5, 0, 0, 0, 0, 0, 0, 0);
        // R9 external inputs blocked
        step(0, 0, 0, 0, 0, 0, 1, 8'h3C, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 8'h11, 1, 0, 0);
        // R8 break edges
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R13 tx and rising break together
        step(0, 0, 1, 8'h5A, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // leave loopback: R5 modem ris kept, R11 flags from pins
        step(1, 16'h3F00, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 external break wins, byte, tx no push
        step(0, 0, 0, 0, 0, 0, 1, 8'h77, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 8'hC3, 0, 0, 0);
        step(0, 0, 1, 8'h99, 0, 0, 0, 0, 0, 0, 0);
        // R8 history tracked outside loopback: rise here, then loopback hold
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        step(1, 16'h0080, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        // R12 clear with concurrent tx set
        step(0, 0, 1, 8'h01, 0, 0, 0, 0, 0, 1, 11'h7FF);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 11'h7FF);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] cd;
            cd = 16'($urandom);
            cd[7] = ($urandom_range(0, 2) != 0);
            step(($urandom_range(0, 7) == 0), cd,
                 ($urandom_range(0, 3) == 0), 8'($urandom),
                 ($urandom_range(0, 3) == 0), 1'($urandom),
                 ($urandom_range(0, 2) == 0), 8'($urandom),
                 ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 4) == 0), 11'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule